// File: doc/BRIEF.md
# Triggered DAC Data Path with Wave Generator

This block is the digital front end of a 6-bit converter channel. Software reaches it through a small write port. The port has four locations: a control word, a software trigger bit, a 6-bit holding value and a status word that clears on write. The block moves the holding value into the output code, which feeds the analog converter. When triggering is off, the output code follows the holding value one clock later. When triggering is on, a move happens only after a trigger from the selected source.

When triggering is on, the block can add a wave to the holding value as it moves it. The wave is either a masked pseudo-random noise value or a triangle counter. A DMA request is raised for each triggered move. If a new triggered move happens while the previous request is still unacknowledged, an underrun flag is set, and the flag can raise an interrupt.

A trigger sequencer decides when moves happen. It has five named states:
- IDLE waits for a trigger.
- WAIT1 and WAIT2 are the two delay stages after a hardware trigger.
- LOAD performs the hardware-triggered move.
- SWDONE clears the software trigger bit.

Its transitions are:
- IDLE to SWDONE on a pending software trigger, with the move made on that same edge.
- IDLE to WAIT1 on a hardware event from the selected source.
- WAIT1 to WAIT2, then WAIT2 to LOAD, then LOAD to IDLE.
- SWDONE to IDLE.
- WAIT1 and WAIT2 fall back to IDLE if the channel is disabled or triggering is turned off.

Top module: `trig_dac_front`

## Requirements
- R1: With enable (control bit 0) set and trigger enable (control bit 2) clear, a value written to the holding location (address 2, bits 5:0) appears on `dac_out` on the clock after the write edge.
- R2: With trigger enable set and trigger select (control bits 5:3) equal to 000 (`timer_evt`) or 001 (`pin_evt`), an event sampled high while the sequencer is idle loads `dac_out` on the third clock edge after the sampling edge. The event of the unselected source is ignored.
- R3: With trigger select 111, writing 1 to bit 0 of address 1 sets `sw_pending`. `dac_out` loads on the next clock edge, and `sw_pending` returns low one clock after that load.
- R4: Trigger select codes 010 through 110 cause no load, whatever happens on the event inputs.
- R5: Wave mode (control bits 7:6) 01 selects noise. The loaded value is (hold + (lfsr & mask)) mod 64, taken before the register advances. The register resets to 000001, and each noise load advances it with next = {l[4:0], l[5]^l[4]}. The mask for code c (control bits 11:8) is 2^(min(c,5)+1)-1.
- R6: Wave mode 10 or 11 selects triangle. The loaded value is (hold + t) mod 64. The counter t starts at 0 counting up, steps by one per triangle load up to the amplitude 2^(min(c,5)+1)-1, then steps down to 0 and repeats.
- R7: With wave mode 00, or with trigger enable clear, no wave is added.
- R8: With enable clear, `dac_out` holds its value, and writes and triggers leave it unchanged.
- R9: With DMA enable (control bit 12) set, each triggered load sets `dma_req`. `dma_req` stays high until `dma_ack` is seen without a simultaneous load.
- R10: A triggered load with DMA enable set while `dma_req` is already high sets `udr_flag`. Writing 1 to bit 0 of address 3 clears it. `udr_irq` equals `udr_flag` gated by the interrupt enable (control bit 13).
- R11: After reset `dac_out`, `sw_pending`, `dma_req`, `udr_flag` and `udr_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Location: 0 control, 1 software trigger, 2 holding value, 3 status |
| wr_data | input | 14 | Write data |
| timer_evt | input | 1 | Timer trigger event |
| pin_evt | input | 1 | Pin trigger event |
| dma_ack | input | 1 | DMA acknowledge |
| dac_out | output | 6 | Output code to the converter |
| sw_pending | output | 1 | Software trigger bit |
| dma_req | output | 1 | DMA request |
| udr_flag | output | 1 | Underrun flag |
| udr_irq | output | 1 | Underrun interrupt |

## Verification
The bench runs the move path under four trigger patterns: free-running transfer, timer events, pin events and software triggers. It checks the output on the exact edge of each mode, which tells the one-clock and three-clock latencies apart. Random holding values, wave modes and mask codes up to 15 are checked against a bench model of the noise register and the triangle counter, so mask saturation, the triangle turning points and wave suppression all show up. Directed cases cover reserved select codes, the wrong-source event, a disabled channel, and two unacknowledged loads that raise and then clear the underrun.

// File: rtl/trig_dac_pkg.sv
package trig_dac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WAIT1  = 3'd1,
        ST_WAIT2  = 3'd2,
        ST_LOAD   = 3'd3,
        ST_SWDONE = 3'd4
    } tseq_e;

    typedef struct packed {
        logic       udrie;
        logic       dmaen;
        logic [3:0] mamp;
        logic [1:0] wave;
        logic [2:0] tsel;
        logic       ten;
        logic       spare;
        logic       en;
    } ctrl_t;

    localparam logic [2:0] SRC_TIMER = 3'b000;
    localparam logic [2:0] SRC_PIN   = 3'b001;
    localparam logic [2:0] SRC_SW    = 3'b111;

    localparam logic [1:0] LOC_CTRL   = 2'd0;
    localparam logic [1:0] LOC_SWTRIG = 2'd1;
    localparam logic [1:0] LOC_HOLD   = 2'd2;
    localparam logic [1:0] LOC_STATUS = 2'd3;

    localparam logic [1:0] WAVE_NOISE = 2'b01;

endpackage

// File: rtl/dac_wave_gen.sv
module dac_wave_gen #(
    parameter int DW = 6,
    parameter int CW = 4,
    parameter logic [DW-1:0] TAPS = 6'b110000,
    parameter logic [DW-1:0] SEED = 6'b000001
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          wave_on,
    input  logic [1:0]    mode,
    input  logic [CW-1:0] code,
    input  logic [DW-1:0] base,
    output logic [DW-1:0] sum
);
    import trig_dac_pkg::*;

    localparam int            TOP = DW - 1;
    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};
    localparam logic [DW-1:0] ALL = {DW{1'b1}};

    logic [DW-1:0] lfsr_q, tri_q, mask, addend;
    logic          up_q, fb;
    int            n;

    always_comb begin
        n    = (int'(code) > TOP) ? TOP : int'(code);
        mask = ALL >> (TOP - n);
    end

    assign fb = ^(lfsr_q & TAPS);

    always_comb begin
        addend = '0;
        if (wave_on) begin
            if (mode == WAVE_NOISE) addend = lfsr_q & mask;
            else if (mode[1])       addend = tri_q;
        end
    end

    assign sum = base + addend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
        end else if (step && wave_on && mode == WAVE_NOISE) begin
            lfsr_q <= {lfsr_q[DW-2:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tri_q <= '0;
            up_q  <= 1'b1;
        end else if (step && wave_on && mode[1]) begin
            if (up_q) begin
                if (tri_q >= mask) begin
                    up_q  <= 1'b0;
                    tri_q <= tri_q - ONE;
                end else begin
                    tri_q <= tri_q + ONE;
                end
            end else begin
                if (tri_q == '0) begin
                    up_q  <= 1'b1;
                    tri_q <= ONE;
                end else begin
                    tri_q <= tri_q - ONE;
                end
            end
        end
    end

    // R5
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

    // R6
    tri_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tri_q) |-> ((tri_q - $past(tri_q)) == ONE || ($past(tri_q) - tri_q) == ONE));

endmodule

// File: rtl/dac_trig_fsm.sv
module dac_trig_fsm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       armed,
    input  logic [2:0] tsel,
    input  logic       timer_evt,
    input  logic       pin_evt,
    input  logic       sw_pend,
    output logic       load_pulse,
    output logic       sw_clear
);
    import trig_dac_pkg::*;

    tseq_e state_q, state_d;
    logic  hw_hit, sw_hit;

    assign hw_hit = (tsel == SRC_TIMER && timer_evt) || (tsel == SRC_PIN && pin_evt);
    assign sw_hit = (tsel == SRC_SW) && sw_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (armed && sw_hit)      state_d = ST_SWDONE;
                else if (armed && hw_hit) state_d = ST_WAIT1;
            end
            ST_WAIT1:  state_d = armed ? ST_WAIT2 : ST_IDLE;
            ST_WAIT2:  state_d = armed ? ST_LOAD  : ST_IDLE;
            ST_LOAD:   state_d = ST_IDLE;
            ST_SWDONE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_pulse = 1'b0;
        sw_clear   = 1'b0;
        unique case (state_q)
            ST_IDLE:   load_pulse = armed && sw_hit;
            ST_LOAD:   load_pulse = armed;
            ST_SWDONE: sw_clear   = 1'b1;
            default: ;
        endcase
    end

    // R2
    hw_three_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |-> ($past(state_q, 3) == ST_IDLE));

endmodule

// File: rtl/trig_dac_front.sv
module trig_dac_front #(
    parameter int DW   = 6,
    parameter int CW   = 4,
    parameter int AW   = 2,
    parameter int WR_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [WR_W-1:0] wr_data,
    input  logic            timer_evt,
    input  logic            pin_evt,
    input  logic            dma_ack,
    output logic [DW-1:0]   dac_out,
    output logic            sw_pending,
    output logic            dma_req,
    output logic            udr_flag,
    output logic            udr_irq
);
    import trig_dac_pkg::*;

    ctrl_t         ctrl_q;
    logic [DW-1:0] hold_q, out_q, wave_sum;
    logic          sw_q, dreq_q, udr_q;
    logic          load_pulse, sw_clear, armed;
    logic          wr_ctrl, wr_sw, wr_hold, wr_stat;
    logic          unused_spare;

    assign unused_spare = wr_data[1];
    assign wr_ctrl = wr_en && wr_addr == LOC_CTRL;
    assign wr_sw   = wr_en && wr_addr == LOC_SWTRIG;
    assign wr_hold = wr_en && wr_addr == LOC_HOLD;
    assign wr_stat = wr_en && wr_addr == LOC_STATUS;
    assign armed   = ctrl_q.en && ctrl_q.ten;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            hold_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q       <= ctrl_t'(wr_data);
                ctrl_q.spare <= 1'b0;
            end
            if (wr_hold) hold_q <= wr_data[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               sw_q <= 1'b0;
        else if (sw_clear)        sw_q <= 1'b0;
        else if (wr_sw && wr_data[0]) sw_q <= 1'b1;
    end

    dac_trig_fsm u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed      (armed),
        .tsel       (ctrl_q.tsel),
        .timer_evt  (timer_evt),
        .pin_evt    (pin_evt),
        .sw_pend    (sw_q),
        .load_pulse (load_pulse),
        .sw_clear   (sw_clear)
    );

    dac_wave_gen #(.DW(DW), .CW(CW)) u_wave (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (load_pulse),
        .wave_on (ctrl_q.ten),
        .mode    (ctrl_q.wave),
        .code    (ctrl_q.mamp),
        .base    (hold_q),
        .sum     (wave_sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              out_q <= '0;
        else if (!ctrl_q.en)     out_q <= out_q;
        else if (!ctrl_q.ten)    out_q <= hold_q;
        else if (load_pulse)     out_q <= wave_sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dreq_q <= 1'b0;
            udr_q  <= 1'b0;
        end else begin
            if (load_pulse && ctrl_q.dmaen) dreq_q <= 1'b1;
            else if (dma_ack)               dreq_q <= 1'b0;
            if (load_pulse && ctrl_q.dmaen && dreq_q) udr_q <= 1'b1;
            else if (wr_stat && wr_data[0])           udr_q <= 1'b0;
        end
    end

    assign dac_out    = out_q;
    assign sw_pending = sw_q;
    assign dma_req    = dreq_q;
    assign udr_flag   = udr_q;
    assign udr_irq    = udr_q && ctrl_q.udrie;

    // R1
    free_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.en && !ctrl_q.ten) |=> (dac_out == $past(hold_q)));

    // R8
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.en |=> $stable(dac_out));

    // R9
    dma_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack) |=> dma_req);

    // R10
    udr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(udr_flag) |-> $past(dma_req));

    // R3
    sw_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_pending) |-> $past(sw_pending, 2));

endmodule

// File: tb/trig_dac_front_test.sv
`timescale 1ns/1ps
module trig_dac_front_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [13:0] wr_data = '0;
    logic        timer_evt = 1'b0, pin_evt = 1'b0, dma_ack = 1'b0;
    logic [5:0]  dac_out;
    logic        sw_pending, dma_req, udr_flag, udr_irq;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [5:0] m_lfsr = 6'd1, m_tri = 6'd0, m_out = 6'd0;
    bit         m_up = 1, m_dma = 0, m_udr = 0, m_ie = 0;

    always #2 clk = ~clk;

    trig_dac_front uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .timer_evt(timer_evt), .pin_evt(pin_evt), .dma_ack(dma_ack),
        .dac_out(dac_out), .sw_pending(sw_pending), .dma_req(dma_req),
        .udr_flag(udr_flag), .udr_irq(udr_irq)
    );

    function automatic logic [5:0] mask_of(input logic [3:0] c);
        int k = (c > 5) ? 5 : int'(c);
        return 6'h3F >> (5 - k);
    endfunction

    function automatic logic [13:0] ctl(input bit en, input bit ten, input logic [2:0] ts,
        input logic [1:0] wv, input logic [3:0] ma, input bit dm, input bit ie);
        return {ie, dm, ma, wv, ts, ten, 1'b0, en};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [13:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic model_load(input logic [5:0] h, input logic [1:0] wv, input logic [3:0] ma);
        logic [5:0] mk = mask_of(ma);
        if (wv == 2'b01) begin
            m_out  = h + (m_lfsr & mk);
            m_lfsr = {m_lfsr[4:0], m_lfsr[5] ^ m_lfsr[4]};
        end else if (wv[1]) begin
            m_out = h + m_tri;
            if (m_up) begin
                if (m_tri >= mk) begin m_up = 0; m_tri = m_tri - 1; end
                else m_tri = m_tri + 1;
            end else begin
                if (m_tri == 0) begin m_up = 1; m_tri = 1; end
                else m_tri = m_tri - 1;
            end
        end else begin
            m_out = h;
        end
        if (m_dma) m_udr = 1;
        m_dma = 1;
    endtask

    task automatic hw_fire(input bit use_pin, input string req);
        @(negedge clk);
        if (use_pin) pin_evt = 1'b1; else timer_evt = 1'b1;
        @(negedge clk); pin_evt = 1'b0; timer_evt = 1'b0;
        repeat (2) @(negedge clk);
        chk({req, " before third edge"}, dac_out, m_out);
    endtask

    task automatic ack();
        @(negedge clk); dma_ack = 1'b1;
        @(negedge clk); dma_ack = 1'b0;
        m_dma = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 dac_out", dac_out, 0);
        chk("R11 flags", {sw_pending, dma_req, udr_flag, udr_irq}, 0);

        // R1 and R7: free transfer, wave mode ignored without trigger enable
        wr(0, ctl(1, 0, 3'b000, 2'b01, 4'd3, 0, 0));
        wr(2, 14'h2A);
        chk("R1 not yet", dac_out, 0);
        @(negedge clk);
        chk("R1 follow", dac_out, 6'h2A);
        chk("R7 no wave", dac_out, 6'h2A);
        wr(2, 14'h11); @(negedge clk);
        chk("R1 follow2", dac_out, 6'h11);
        m_out = 6'h11;

        // R8 disabled: writes and triggers ignored
        wr(0, ctl(0, 0, 3'b000, 2'b00, 4'd0, 0, 0));
        wr(2, 14'h05); @(negedge clk);
        chk("R8 write ignored", dac_out, 6'h11);
        wr(0, ctl(0, 1, 3'b000, 2'b00, 4'd0, 0, 0));
        hw_fire(0, "R8");
        @(negedge clk);
        chk("R8 trigger ignored", dac_out, 6'h11);

        // R2 timer source, hold 0x05, wave off
        wr(0, ctl(1, 1, 3'b000, 2'b00, 4'd0, 0, 0));
        hw_fire(1, "R2 wrong source");
        repeat (2) @(negedge clk);
        chk("R2 pin ignored on timer select", dac_out, 6'h11);
        hw_fire(0, "R2 timer");
        @(negedge clk);
        chk("R2 timer load", dac_out, 6'h05);
        m_out = 6'h05; m_dma = 0;

        // R4 reserved select codes
        wr(2, 14'h33);
        for (int c = 2; c <= 6; c++) begin
            wr(0, ctl(1, 1, 3'(c), 2'b00, 4'd0, 0, 0));
            hw_fire(0, "R4"); hw_fire(1, "R4");
            @(negedge clk);
            chk("R4 reserved code", dac_out, 6'h05);
        end

        // R3 software trigger timing
        wr(0, ctl(1, 1, 3'b111, 2'b00, 4'd0, 0, 0));
        wr(1, 14'h1);
        chk("R3 pending set", sw_pending, 1);
        chk("R3 no load yet", dac_out, 6'h05);
        @(negedge clk);
        chk("R3 load one clock", dac_out, 6'h33);
        chk("R3 pending during load clock", sw_pending, 1);
        @(negedge clk);
        chk("R3 self clear", sw_pending, 0);
        m_out = 6'h33;

        // R9 and R10 directed underrun
        wr(0, ctl(1, 1, 3'b111, 2'b00, 4'd0, 1, 1));
        m_ie = 1;
        wr(1, 14'h1); repeat (2) @(negedge clk);
        chk("R9 request raised", dma_req, 1);
        chk("R10 no underrun yet", udr_flag, 0);
        wr(1, 14'h1); repeat (2) @(negedge clk);
        chk("R10 underrun set", udr_flag, 1);
        chk("R10 irq", udr_irq, 1);
        wr(3, 14'h1);
        chk("R10 cleared", {udr_flag, udr_irq}, 0);
        chk("R9 request held", dma_req, 1);
        ack();
        chk("R9 ack clears", dma_req, 0);
        m_dma = 0; m_udr = 0;

        // R5 R6 R9 R10 random triggered loads
        void'($urandom(32'h0005EED5));
        for (int it = 0; it < 80; it++) begin
            logic [5:0] h  = 6'($urandom);
            logic [1:0] wv = 2'($urandom);
            logic [3:0] ma = 4'($urandom);
            int         kd = int'($urandom % 3);
            bit         ie = bit'($urandom % 2);
            string      rq = (wv == 2'b01) ? "R5" : (wv[1] ? "R6" : "R7");
            m_ie = ie;
            wr(2, 14'(h));
            wr(0, ctl(1, 1, (kd == 2) ? 3'b111 : 3'(kd), wv, ma, 1, ie));
            if ($urandom % 2 == 1) ack();
            if ($urandom % 8 == 0) begin wr(3, 14'h1); m_udr = 0; end
            model_load(h, wv, ma);
            if (kd == 2) begin
                wr(1, 14'h1); @(negedge clk);
            end else begin
                m_out = m_out; // pre-load value checked inside hw_fire is the previous one
                begin
                    logic [5:0] nxt = m_out;
                    m_out = dac_out;
                    hw_fire(kd == 1, rq);
                    m_out = nxt;
                end
                @(negedge clk);
            end
            chk({rq, " wave value"}, dac_out, m_out);
            chk("R9 dma_req", dma_req, m_dma);
            chk("R10 udr_flag", udr_flag, m_udr);
            chk("R10 udr_irq", udr_irq, m_udr & m_ie);
            @(negedge clk);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule